// File: doc/BRIEF.md
# Banked Word Memory with Region Decoder

This block is a word-wide synchronous memory of 8K words of 16 bits. It is built from four byte-wide banks of 4096 entries each, arranged as two pairs. Every access uses one pair. Within that pair, one bank holds the high byte of the word and the other holds the low byte. Both banks of the pair see the same 12-bit location index and the same write strobe, so a word is always read or written as a whole.

A 2-to-4 decoder looks at the two address bits above the location index and produces four region selects that are 4K words apart. Regions 0 and 1 enable the first and second pair, so address bit 12 chooses the pair. Regions 2 and 3 have no storage behind them. An access that lands there stores nothing, returns zero and raises a one-cycle flag. The global select gates the decoder, so no bank is enabled while the block is idle.

Top module: `banked_word_mem`

## Requirements
- R1: While reset is asserted, `rdata_o` is zero and `unmapped_o` is low.
- R2: A read (select high, write low) to a mapped address returns the stored 16-bit word on `rdata_o` in the cycle after the request.
- R3: A write (select and write both high) stores all 16 bits of `wdata_i` at the clock edge. In the following cycle `rdata_o` is zero.
- R4: Address bit 12 picks the bank pair. Two addresses that differ only in bit 12 hold independent words.
- R5: Address bits 11..0 pick the location inside a pair. Locations 0x000 and 0xFFF of one pair hold independent words.
- R6: Bits 15..8 of a word sit in the high-byte bank and bits 7..0 in the low-byte bank. Two different byte values written together come back in their own positions.
- R7: Address bits 13..12 equal to 2 or 3 select a vacant region. Such an access changes no stored word. In the next cycle it drives `rdata_o` to zero and `unmapped_o` high for one cycle.
- R8: With select low, the cycle after gives `rdata_o` zero and `unmapped_o` low, and a high write input stores nothing.
- R9: A read followed directly by a write to the same address returns the old word during the write cycle. A later read returns the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Global select; gates the region decoder |
| we_i | input | 1 | 1 = write word, 0 = read word |
| addr_i | input | 14 | [13:12] region (bit 12 = pair), [11:0] location |
| wdata_i | input | 16 | Write word |
| rdata_o | output | 16 | Read word, one cycle after request; zero otherwise |
| unmapped_o | output | 1 | High for one cycle after an access to a vacant region |

## Verification
The read path and the write path can be busy in the same cycle. The read result of one request is on `rdata_o` while the next request writes the same location. The bench provokes this with a read immediately followed by a write to the same word. It expects the old word in the write cycle, zero in the cycle after, and the new word on a later read. It also sends a vacant-region write whose low twelve bits match a stored word, then reads that word back to confirm it was not disturbed.

// File: rtl/banked_mem_pkg.sv
package banked_mem_pkg;
  localparam int unsigned BANK_AW_D   = 12;  // location bits per bank
  localparam int unsigned REGION_W_D  = 2;   // decoded region bits
  localparam int unsigned NUM_PAIRS_D = 2;   // populated regions
  localparam int unsigned DATA_W_D    = 16;
  localparam int unsigned LANE_W_D    = 8;

  typedef logic [DATA_W_D-1:0] word_t;
endpackage

// File: rtl/region_decoder.sv
module region_decoder #(
  parameter int unsigned IN_W = 2,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic             en_i,
  input  logic [IN_W-1:0]  code_i,
  output logic [OUT_N-1:0] sel_o
);
  for (genvar g = 0; g < OUT_N; g++) begin : g_out
    assign sel_o[g] = en_i && (code_i == IN_W'(g));
  end
endmodule

// File: rtl/byte_bank.sv
module byte_bank #(
  parameter int unsigned AW = 12,
  parameter int unsigned W  = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (cs_i && we_i)  mem_q[addr_i] <= wdata_i;
    if (cs_i && !we_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/bank_pair.sv
module bank_pair #(
  parameter int unsigned AW     = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  // lane LANES-1 is the high-byte bank; all lanes share cs, we and addr
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    byte_bank #(.AW(AW), .W(LANE_W)) u_bank (
      .clk_i   (clk_i),
      .cs_i    (cs_i),
      .we_i    (we_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i[l*LANE_W +: LANE_W]),
      .rdata_o (rdata_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/banked_word_mem.sv
module banked_word_mem
  import banked_mem_pkg::*;
#(
  parameter int unsigned BANK_AW   = BANK_AW_D,
  parameter int unsigned REGION_W  = REGION_W_D,
  parameter int unsigned NUM_PAIRS = NUM_PAIRS_D,
  parameter int unsigned DATA_W    = DATA_W_D,
  parameter int unsigned LANE_W    = LANE_W_D,
  localparam int unsigned AW   = BANK_AW + REGION_W,
  localparam int unsigned NREG = 1 << REGION_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              unmapped_o
);
  logic [REGION_W-1:0] region;
  logic [NREG-1:0]     region_sel;
  logic [NREG-1:0]     vacant_hit;
  logic [DATA_W-1:0]   pair_rdata [NREG];
  logic                unmapped_d;
  logic                rd_q;
  logic [REGION_W-1:0] pair_q;
  logic                unmapped_q;

  assign region = addr_i[AW-1:BANK_AW];

  region_decoder #(.IN_W(REGION_W)) u_dec (
    .en_i   (sel_i),
    .code_i (region),
    .sel_o  (region_sel)
  );

  for (genvar p = 0; p < NREG; p++) begin : g_region
    if (p < NUM_PAIRS) begin : g_pair
      bank_pair #(.AW(BANK_AW), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_pair (
        .clk_i   (clk_i),
        .cs_i    (region_sel[p]),
        .we_i    (we_i),
        .addr_i  (addr_i[BANK_AW-1:0]),
        .wdata_i (wdata_i),
        .rdata_o (pair_rdata[p])
      );
      assign vacant_hit[p] = 1'b0;
    end else begin : g_vacant
      assign pair_rdata[p] = '0;
      assign vacant_hit[p] = region_sel[p];
    end
  end

  assign unmapped_d = |vacant_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q       <= 1'b0;
      pair_q     <= '0;
      unmapped_q <= 1'b0;
    end else begin
      rd_q       <= sel_i && !we_i && !unmapped_d;
      pair_q     <= region;
      unmapped_q <= unmapped_d;
    end
  end

  assign rdata_o    = rd_q ? pair_rdata[pair_q] : '0;
  assign unmapped_o = unmapped_q;
endmodule

// File: rtl/banked_word_mem_chk.sv
module banked_word_mem_chk #(
  parameter int unsigned BANK_AW   = 12,
  parameter int unsigned REGION_W  = 2,
  parameter int unsigned NUM_PAIRS = 2,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned AW = BANK_AW + REGION_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [AW-1:0]     addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              unmapped_o
);
  logic vacant_req;
  assign vacant_req = sel_i && (int'(addr_i[AW-1:BANK_AW]) >= int'(NUM_PAIRS));

  assert_vacant_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vacant_req |=> unmapped_o && (rdata_o == '0));

  assert_flag_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> $past(vacant_req));

  assert_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (rdata_o == '0) && !unmapped_o);

  assert_write_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && we_i |=> (rdata_o == '0));

  assert_write_then_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && !vacant_req) ##1 (sel_i && !we_i && (addr_i == $past(addr_i)))
    |=> rdata_o == $past(wdata_i, 2));
endmodule

bind banked_word_mem banked_word_mem_chk #(
  .BANK_AW(BANK_AW), .REGION_W(REGION_W), .NUM_PAIRS(NUM_PAIRS), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .unmapped_o(unmapped_o)
);

// File: tb/banked_word_mem_test.sv
`timescale 1ns/1ps
module banked_word_mem_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        we_i = 1'b0;
  logic [13:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        unmapped_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  banked_word_mem uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .unmapped_o(unmapped_o)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one request at a falling edge; return at the next falling edge
  task automatic cyc(input logic s, input logic w, input logic [13:0] a, input logic [15:0] d);
    sel_i = s; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, '0, '0);
  endtask

  task automatic wr(input logic [13:0] a, input logic [15:0] d, input string req);
    cyc(1'b1, 1'b1, a, d);
    chk(rdata_o, 16'h0000, req);
  endtask

  task automatic rd(input logic [13:0] a, input logic [15:0] exp, input string req);
    cyc(1'b1, 1'b0, a, 16'hxxxx);
    chk(rdata_o, exp, req);
    chk({15'b0, unmapped_o}, 16'h0000, req);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk_i);
    chk(rdata_o, 16'h0000, "R1 rdata in reset");
    chk({15'b0, unmapped_o}, 16'h0000, "R1 flag in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_basic();
    wr(14'h0005, 16'hA55A, "R3 write cycle output");
    rd(14'h0005, 16'hA55A, "R2 read back");
    idle();
    chk(rdata_o, 16'h0000, "R2 output clears after read");
  endtask

  task automatic t_pairs();
    wr(14'h0123, 16'h1111, "R4 write pair 0");
    wr(14'h1123, 16'h2222, "R4 write pair 1");
    rd(14'h0123, 16'h1111, "R4 pair 0 independent");
    rd(14'h1123, 16'h2222, "R4 pair 1 independent");
  endtask

  task automatic t_lanes();
    wr(14'h0000, 16'h00FF, "R5 write loc 0");
    wr(14'h0FFF, 16'hC33C, "R5 write loc FFF");
    rd(14'h0000, 16'h00FF, "R6 bytes at loc 0");
    rd(14'h0FFF, 16'hC33C, "R5 loc FFF independent");
    wr(14'h1FFF, 16'h7E81, "R6 write pair 1 top");
    rd(14'h1FFF, 16'h7E81, "R6 bytes in place");
  endtask

  task automatic t_vacant();
    cyc(1'b1, 1'b1, 14'h2123, 16'hDEAD);
    chk({15'b0, unmapped_o}, 16'h0001, "R7 flag on region 2 write");
    chk(rdata_o, 16'h0000, "R7 zero on region 2 write");
    cyc(1'b1, 1'b0, 14'h3123, 16'h0000);
    chk({15'b0, unmapped_o}, 16'h0001, "R7 flag on region 3 read");
    chk(rdata_o, 16'h0000, "R7 zero on region 3 read");
    idle();
    chk({15'b0, unmapped_o}, 16'h0000, "R7 flag is a pulse");
    rd(14'h0123, 16'h1111, "R7 vacant write stored nothing");
  endtask

  task automatic t_idle();
    rd(14'h0005, 16'hA55A, "R8 setup read");
    cyc(1'b0, 1'b1, 14'h0005, 16'h0BAD);
    chk(rdata_o, 16'h0000, "R8 zero when deselected");
    chk({15'b0, unmapped_o}, 16'h0000, "R8 flag low when deselected");
    cyc(1'b0, 1'b0, 14'h2000, 16'h0000);
    chk({15'b0, unmapped_o}, 16'h0000, "R8 no flag for deselected vacant address");
    rd(14'h0005, 16'hA55A, "R8 deselected write ignored");
  endtask

  task automatic t_b2b();
    cyc(1'b1, 1'b0, 14'h1123, 16'h0000);
    chk(rdata_o, 16'h2222, "R9 old word after read");
    cyc(1'b1, 1'b1, 14'h1123, 16'h3333);
    chk(rdata_o, 16'h0000, "R9 zero after write");
    rd(14'h1123, 16'h3333, "R9 new word");
    rd(14'h0123, 16'h1111, "R9 other pair untouched");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_pairs();
    t_lanes();
    t_vacant();
    t_idle();
    t_b2b();
    idle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule